// File: doc/BRIEF.md
# Dual-Clock Serial Line Delay Memory

This block stores a stream of bytes on one clock and plays them back on another. Each port has its own sequential address pointer, an active-low enable that gates its clock, and an active-low strobe that returns its pointer to address 0. Both pointers wrap by themselves after the last word, so the array behaves as a circular line store whose length need not be a power of two.

A delay line comes from the offset between the two pointers rather than from full or empty flags. If both pointers are reset together and both ports then run every cycle, each word comes out exactly one line after it went in. If the read port is instead held off for some number of cycles after a joint reset, the delay is that number of cycles. The read port has a registered byte output and an output-valid flag, which stands in for a high-impedance output. An advisory flag, fed by a Gray-coded copy of the write pointer carried into the read clock domain, warns when the pointers come too close. The flag never blocks an access.

Top module: `line_delay_mem`

## Requirements
- R1: At a rising `wclk` edge with `wen_n` low and `wrst_n` high, `wdata` is stored at the write pointer and the pointer advances by one.
- R2: At a rising `wclk` edge with `wen_n` high and `wrst_n` high, no word is stored and the write pointer keeps its value.
- R3: At a rising `wclk` edge with `wrst_n` low, the write pointer becomes 0 and no word is stored, even if `wen_n` is low. The next enabled edge writes address 0.
- R4: At a rising `rclk` edge with `ren_n` low and `rrst_n` high, `rdata` takes the word at the read pointer, `rdata_oe` goes high and the read pointer advances by one.
- R5: At a rising `rclk` edge with `rrst_n` low, the read pointer becomes 0, `rdata_oe` goes low and `rdata` holds its value. The next enabled edge outputs the word at address 0.
- R6: Each pointer goes from address DEPTH-1 back to 0 on its next enabled edge.
- R7: At a rising `rclk` edge with `ren_n` high, the read pointer holds and `rdata_oe` goes low. `rdata_oe` returns high on the next edge that has `ren_n` low, and the output continues from the held address.
- R8: After a joint reset of both pointers, with writes enabled on every edge and reads held off for the first d edges (1 <= d <= DEPTH), the read at edge t >= d outputs the word written at edge t-d. When a read and a write hit the same address on the same edge, the read returns the old contents. With d = 0 (both ports running from the first edge), the output at edge DEPTH+k is the word written at edge k.
- R9: After both ports have been idle for at least four read-clock edges, `sep_low` is high if and only if (write pointer - read pointer) mod DEPTH <= MIN_SEP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wen_n | input | 1 | Write enable, active low |
| wrst_n | input | 1 | Write pointer reset, active low, synchronous to `wclk` |
| wdata | input | DW | Byte to be stored |
| rclk | input | 1 | Read-side clock |
| ren_n | input | 1 | Read enable, active low |
| rrst_n | input | 1 | Read pointer reset, active low, synchronous to `rclk` |
| rdata | output | DW | Registered read byte |
| rdata_oe | output | 1 | High when `rdata` is driven, and low in place of high impedance |
| sep_low | output | 1 | Advisory flag: pointer separation at or below MIN_SEP |

## Verification
A write pointer that slips or sticks shows up at `rdata` no later than the read that reaches the corrupted address, which is at most one line of read edges later. The bench therefore reads every address after each write-side event. A wrong read pointer shows on the very next enabled read as a byte from the wrong age. The bench sweeps every delay from 1 to DEPTH on a small array and compares each byte with the value computed for that delay. A missed or spurious output-valid change is visible one edge after the enable or reset strobe. Separation errors show on `sep_low` within four read edges of the pointers settling.

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int DW      = 8,
  parameter int DEPTH   = 5048,
  parameter int MIN_SEP = 40
) (
  input  logic          wclk,
  input  logic          wen_n,
  input  logic          wrst_n,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          ren_n,
  input  logic          rrst_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          sep_low
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wptr, wptr_nxt, wgray, wg_s1, wg_s2, wbin_s, rptr;
  logic [AW:0]   sep;

  assign wptr_nxt = !wrst_n ? '0 :
                    wen_n   ? wptr :
                    (wptr == LAST) ? '0 : wptr + 1'b1;

  always_ff @(posedge wclk) begin
    if (wrst_n && !wen_n) store[wptr] <= wdata;
    wptr  <= wptr_nxt;
    wgray <= wptr_nxt ^ (wptr_nxt >> 1);
  end

  always_ff @(posedge rclk) begin
    if (!rrst_n) begin
      rptr     <= '0;
      rdata_oe <= 1'b0;
    end else if (!ren_n) begin
      rdata    <= store[rptr];
      rptr     <= (rptr == LAST) ? '0 : rptr + 1'b1;
      rdata_oe <= 1'b1;
    end else begin
      rdata_oe <= 1'b0;
    end
    wg_s1   <= wgray;
    wg_s2   <= wg_s1;
    sep_low <= (sep <= (AW+1)'(MIN_SEP));
  end

  always_comb
    for (int i = 0; i < AW; i++) wbin_s[i] = ^(wg_s2 >> i);

  assign sep = (wbin_s >= rptr) ? {1'b0, wbin_s} - {1'b0, rptr}
                                : {1'b0, wbin_s} + (AW+1)'(DEPTH) - {1'b0, rptr};

  logic wptr_x, rptr_x;
  assign wptr_x = $isunknown(wptr);
  assign rptr_x = $isunknown(rptr);

  AST_WRST_ZERO:  assert property (@(posedge wclk) !wrst_n |=> wptr == '0);                                          // R3
  AST_WHOLD:      assert property (@(posedge wclk) disable iff (wptr_x) (wrst_n && wen_n) |=> $stable(wptr));        // R2
  AST_WWRAP:      assert property (@(posedge wclk) disable iff (wptr_x) (wrst_n && !wen_n && wptr == LAST) |=> wptr == '0); // R6
  AST_RRANGE:     assert property (@(posedge rclk) disable iff (rptr_x) rptr < AW'(DEPTH));                          // R6
  AST_RRST:       assert property (@(posedge rclk) !rrst_n |=> (rptr == '0 && !rdata_oe));                           // R5
  AST_RD_ON:      assert property (@(posedge rclk) (rrst_n && !ren_n) |=> rdata_oe);                                 // R4
  AST_RD_OFF:     assert property (@(posedge rclk) ren_n |=> !rdata_oe);                                             // R7
  AST_RHOLD:      assert property (@(posedge rclk) disable iff (rptr_x) (rrst_n && ren_n) |=> $stable(rptr));        // R7
endmodule

// File: tb/sim_line_delay_mem.sv
module sim_line_delay_mem;
  localparam int D  = 24;
  localparam int MS = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic wen_n = 1'b1, wrst_n = 1'b1, ren_n = 1'b1, rrst_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, sep_low;

  line_delay_mem #(.DW(8), .DEPTH(D), .MIN_SEP(MS)) u0 (
    .wclk(clk), .wen_n(wen_n), .wrst_n(wrst_n), .wdata(wdata),
    .rclk(clk), .ren_n(ren_n), .rrst_n(rrst_n),
    .rdata(rdata), .rdata_oe(rdata_oe), .sep_low(sep_low));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input int t, input int d);
    return 8'((t * 7 + d * 13 + 5) & 8'hFF);
  endfunction

  task automatic joint_reset();
    wrst_n = 1'b0; rrst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1;
    tick();
    wrst_n = 1'b1; rrst_n = 1'b1;
  endtask

  task automatic read_reset();
    rrst_n = 1'b0;
    tick();
    rrst_n = 1'b1;
    chk(rdata_oe == 1'b0, "R5 oe after read reset", int'(rdata_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1 watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    tick(); tick();
    joint_reset();
    chk(rdata_oe == 1'b0, "R5 reset state oe", int'(rdata_oe), 0);

    for (int d = 1; d <= D; d++) begin
      joint_reset();
      for (int t = 0; t < d + 2 * D; t++) begin
        wen_n = 1'b0; wdata = pat(t, d); ren_n = (t < d);
        tick();
        if (t >= d) begin
          chk(rdata_oe == 1'b1, "R4 oe on read", int'(rdata_oe), 1);
          chk(rdata == pat(t - d, d), "R8 delayed byte", int'(rdata), int'(pat(t - d, d)));
        end else begin
          chk(rdata_oe == 1'b0, "R7 oe off while inhibited", int'(rdata_oe), 0);
        end
      end
      wen_n = 1'b1; ren_n = 1'b1;
      repeat (6) tick();
      chk(sep_low == ((d % D) <= MS), "R9 separation flag", int'(sep_low), int'((d % D) <= MS));
    end

    joint_reset();
    for (int t = 0; t < 2 * D; t++) begin
      wen_n = 1'b0; ren_n = 1'b0; wdata = pat(t, 99);
      tick();
      if (t >= D) chk(rdata == pat(t - D, 99), "R8 one-line delay", int'(rdata), int'(pat(t - D, 99)));
    end
    wen_n = 1'b1; ren_n = 1'b1;

    joint_reset();
    for (int k = 0; k < D; k++) begin
      wen_n = 1'b0; wdata = 8'(k) ^ 8'hA5;
      tick();
    end
    wen_n = 1'b1; wdata = 8'h3C;
    repeat (5) tick();
    wen_n = 1'b0; wdata = 8'h77;
    tick();
    wen_n = 1'b1;
    read_reset();
    for (int k = 0; k < D; k++) begin
      ren_n = 1'b0;
      tick();
      if (k == 0) chk(rdata == 8'h77, "R6 write wrap to address 0", int'(rdata), 'h77);
      else chk(rdata == (8'(k) ^ 8'hA5), "R2 inhibited write left data", int'(rdata), int'(8'(k) ^ 8'hA5));
    end
    held = rdata;
    ren_n = 1'b1;
    tick();
    chk(rdata_oe == 1'b0, "R7 oe off", int'(rdata_oe), 0);
    chk(rdata == held, "R7 data held while inhibited", int'(rdata), int'(held));
    ren_n = 1'b0;
    tick();
    chk(rdata_oe == 1'b1, "R7 oe back on", int'(rdata_oe), 1);
    chk(rdata == 8'h77, "R6 read wrap to address 0", int'(rdata), 'h77);
    tick();
    chk(rdata == (8'h01 ^ 8'hA5), "R4 read pointer advanced", int'(rdata), int'(8'h01 ^ 8'hA5));
    held = rdata;
    rrst_n = 1'b0;
    tick();
    rrst_n = 1'b1;
    chk(rdata_oe == 1'b0, "R5 oe low on reset edge", int'(rdata_oe), 0);
    chk(rdata == held, "R5 data held on reset edge", int'(rdata), int'(held));
    tick();
    chk(rdata == 8'h77, "R5 first read after reset is address 0", int'(rdata), 'h77);
    ren_n = 1'b1;

    wrst_n = 1'b0; wen_n = 1'b0; wdata = 8'h55;
    tick();
    wrst_n = 1'b1; wen_n = 1'b1;
    read_reset();
    ren_n = 1'b0;
    tick();
    chk(rdata == 8'h77, "R3 no write on reset edge addr0", int'(rdata), 'h77);
    tick();
    chk(rdata == (8'h01 ^ 8'hA5), "R3 no write on reset edge addr1", int'(rdata), int'(8'h01 ^ 8'hA5));
    ren_n = 1'b1;
    wen_n = 1'b0; wdata = 8'h66;
    tick();
    wen_n = 1'b0; wdata = 8'h67;
    tick();
    wen_n = 1'b1;
    read_reset();
    ren_n = 1'b0;
    tick();
    chk(rdata == 8'h66, "R3 first write after reset at address 0", int'(rdata), 'h66);
    tick();
    chk(rdata == 8'h67, "R1 write pointer advanced", int'(rdata), 'h67);
    ren_n = 1'b1;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule